// File: doc/BRIEF.md
# External-Clock Period Timer

This block is a 16-bit period timer whose counting events are rising edges of an external clock pin. Edges first pass through a selectable divider: 1, 8, 64 or 256. The count then advances by one. When it reaches the value held in a period register, the timer signals a match. The next counted edge returns the count to zero, and the cycle repeats for as long as the timer stays enabled.

Two counting paths are available, selected by a control bit. In synchronized mode the external clock is sampled by two flops on the bus clock, and a rising-edge detector produces a one-cycle count enable. In unsynchronized mode the counter runs directly on the external clock, so it keeps counting with the bus clock stopped. In that mode the match is a pulse in the external domain that can serve as a wake signal, and a toggle synchronizer also carries it into the bus domain.

Software programs the block through a control register, a count register and a period register. The count and period registers accept writes only while the timer is disabled.

Top module: `xclk_period_timer`

## Requirements
- R1: After reset, the control, count and period read-backs are 0 and both match outputs are low.
- R2: Control register fields: bit 15 enable, bits 5:4 prescale code, bit 2 sync mode, bit 1 external source select. All other bits read back as 0, so writing 0xFFFF reads back 0x8036.
- R3: In sync mode with prescale code 2'b00, each counted rising edge of `ext_clk` raises the count by one. The new value is visible within 3 bus clock cycles of the edge.
- R4: When the count reaches the period value, a match is raised. The next counted edge sets the count to 0x0000. A period of 0 gives a match on every counted edge, with the count held at 0.
- R5: After enable goes from 0 to 1, the first two rising edges of `ext_clk` are not counted, whatever the prescale code.
- R6: Prescale codes 2'b00, 2'b01, 2'b10 and 2'b11 count every 1st, 8th, 64th and 256th external edge.
- R7: Clearing enable keeps the count value but resets the prescaler and the startup edge counter.
- R8: Writes to the count and period registers are ignored while enable is 1 and accepted while it is 0.
- R9: In unsync mode (bit 2 = 0) the count advances on `ext_clk` even while the bus clock is stopped. In sync mode it does not advance while the bus clock is stopped.
- R10: `wake_o` is high for one counting-domain clock, starting at the edge where the count reaches the period. `match_o` is a one-bus-cycle pulse per match. In unsync mode it follows within 5 bus cycles once the bus clock runs.
- R11: With the external source select bit at 0, external edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External clock pin being counted |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count register write data |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period register write data |
| ctl_q | output | 16 | Control register read-back |
| cnt_q | output | 16 | Current count |
| per_q | output | 16 | Period register read-back |
| match_o | output | 1 | Match pulse, bus clock domain |
| wake_o | output | 1 | Match pulse, counting clock domain |

## Verification
In sync mode, a rising edge on `ext_clk` reaches the count on the third bus clock edge after it, and `match_o` follows one bus cycle later. In unsync mode the count changes at the external edge itself, and `match_o` appears three to four bus cycles later. Each external pulse is held high and then low for six bus cycles. The expected count and match totals are queued only after the pulse completes, and the monitor compares them on a falling bus clock edge, past every one of those latencies. While the bus clock is stopped the bench compares the count directly after each external edge. After restarting the clock it waits ten cycles before checking the delayed bus-domain match.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int CTL_W    = 16;
  localparam int EN_BIT   = 15;
  localparam int PS_LO    = 4;
  localparam int SYNC_BIT = 2;
  localparam int SRC_BIT  = 1;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV8   = 2'b01,
    PS_DIV64  = 2'b10,
    PS_DIV256 = 2'b11
  } ps_sel_e;

  function automatic int unsigned ps_ratio(ps_sel_e s);
    case (s)
      PS_DIV1:  return 1;
      PS_DIV8:  return 8;
      PS_DIV64: return 64;
      default:  return 256;
    endcase
  endfunction
endpackage

// File: rtl/xpt_edge_sync.sv
module xpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/xpt_pulse_xfer.sv
module xpt_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q;
  logic            pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      sh_q    <= {sh_q[STAGES-1:0], tgl_i};
      pulse_q <= sh_q[STAGES] ^ sh_q[STAGES-1];
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/xpt_prescale.sv
module xpt_prescale
  import xpt_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    edge_i,
  input  ps_sel_e sel,
  output logic    tick_o
);
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  assign limit  = PW'(ps_ratio(sel) - 1);
  assign tick_o = edge_i && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt_q <= '0;
    else if (edge_i) pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/xpt_core.sv
module xpt_core
  import xpt_pkg::*;
#(
  parameter int W       = 16,
  parameter int PW      = 8,
  parameter int STARTUP = 2
) (
  input  logic         core_clk,
  input  logic         rst,
  input  logic         en,
  input  logic         edge_i,
  input  ps_sel_e      ps_sel,
  input  logic [W-1:0] period,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_o,
  output logic         hit_o,
  output logic         tgl_o
);
  localparam int SU_W = $clog2(STARTUP + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP);

  logic [SU_W-1:0] su_q;
  logic            su_done;
  logic            pre_edge;
  logic            tick;
  logic [W-1:0]    cnt_q;
  logic [W-1:0]    nxt;
  logic            hit_now;
  logic            hit_q;
  logic            tgl_q;

  assign su_done  = (su_q == SU_LAST);
  assign pre_edge = en && edge_i && su_done;

  xpt_prescale #(.PW(PW)) u_pre (
    .clk    (core_clk),
    .rst    (rst),
    .clr    (!en),
    .edge_i (pre_edge),
    .sel    (ps_sel),
    .tick_o (tick)
  );

  assign nxt     = (cnt_q == period) ? '0 : cnt_q + 1'b1;
  assign hit_now = tick && (nxt == period);

  always_ff @(posedge core_clk) begin
    if (rst) begin
      su_q  <= '0;
      cnt_q <= '0;
      hit_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      if (!en)                       su_q <= '0;
      else if (edge_i && !su_done)   su_q <= su_q + 1'b1;

      if (wr_en && !en)              cnt_q <= wr_data;
      else if (tick)                 cnt_q <= nxt;

      hit_q <= hit_now;
      if (hit_now) tgl_q <= ~tgl_q;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit_q;
  assign tgl_o = tgl_q;
endmodule

// File: rtl/xclk_period_timer.sv
module xclk_period_timer
  import xpt_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int PS_W          = 8,
  parameter int STARTUP_EDGES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_q,
  output logic             match_o,
  output logic             wake_o
);
  logic             en_q, sync_q, src_q;
  ps_sel_e          ps_q;
  logic [CNT_W-1:0] per_r;
  logic             core_clk;
  logic             ext_rise;
  logic             core_edge;
  logic             hit;
  logic             tgl;
  logic             xfer_pulse;
  logic             match_q;
  logic             unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[14:6], ctl_wdata[3], ctl_wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sync_q <= 1'b0;
      src_q  <= 1'b0;
      ps_q   <= PS_DIV1;
    end else if (ctl_we) begin
      en_q   <= ctl_wdata[EN_BIT];
      sync_q <= ctl_wdata[SYNC_BIT];
      src_q  <= ctl_wdata[SRC_BIT];
      ps_q   <= ps_sel_e'(ctl_wdata[PS_LO+1:PS_LO]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 per_r <= '0;
    else if (per_we && !en_q) per_r <= per_wdata;
  end

  assign ctl_q = {en_q, 9'b0, ps_q, 1'b0, sync_q, src_q, 1'b0};
  assign per_q = per_r;

  // Counting clock: external pin only while running unsynchronized.
  assign core_clk = (en_q && src_q && !sync_q) ? ext_clk : clk;

  xpt_edge_sync #(.STAGES(SYNC_STAGES)) u_esync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk),
    .rise_o  (ext_rise)
  );

  assign core_edge = src_q && (sync_q ? ext_rise : 1'b1);

  xpt_core #(.W(CNT_W), .PW(PS_W), .STARTUP(STARTUP_EDGES)) u_core (
    .core_clk (core_clk),
    .rst      (rst),
    .en       (en_q),
    .edge_i   (core_edge),
    .ps_sel   (ps_q),
    .period   (per_r),
    .wr_en    (cnt_we),
    .wr_data  (cnt_wdata),
    .cnt_o    (cnt_q),
    .hit_o    (hit),
    .tgl_o    (tgl)
  );

  xpt_pulse_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .tgl_i   (tgl),
    .pulse_o (xfer_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= sync_q ? hit : xfer_pulse;
  end

  assign match_o = match_q;
  assign wake_o  = hit;
endmodule

// File: rtl/xclk_period_timer_chk.sv
module xclk_period_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] ctl_q,
  input logic        cnt_we,
  input logic [15:0] cnt_q,
  input logic [15:0] per_q,
  input logic        match_o,
  input logic        wake_o
);
  logic en, sync_m, src;
  assign en     = ctl_q[15];
  assign sync_m = ctl_q[2];
  assign src    = ctl_q[1];

  // R7: while disabled and not written, the count holds
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en) && !$past(cnt_we)) |-> $stable(cnt_q));

  // R4: in sync mode the count only steps by one or wraps to zero
  assert_step_sync_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(sync_m) && $past(src) && !$stable(cnt_q))
      |-> (cnt_q == 16'($past(cnt_q) + 16'd1) || cnt_q == 16'd0));

  // R8: period register is locked while enabled
  assert_per_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> $stable(per_q));

  // R10: bus-domain match is a single-cycle pulse
  assert_match_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  // R4: in sync mode the bus match coincides with count == period
  assert_match_at_period_R4: assert property (@(posedge clk) disable iff (rst)
    (match_o && en && $past(en) && sync_m && src) |-> (cnt_q == per_q));

  // R10: in sync mode the wake pulse coincides with count == period
  assert_wake_at_period_R10: assert property (@(posedge clk) disable iff (rst)
    (wake_o && en && sync_m && src) |-> (cnt_q == per_q));
endmodule

bind xclk_period_timer xclk_period_timer_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .ctl_q   (ctl_q),
  .cnt_we  (cnt_we),
  .cnt_q   (cnt_q),
  .per_q   (per_q),
  .match_o (match_o),
  .wake_o  (wake_o)
);

// File: tb/xclk_period_timer_tb_top.sv
module xclk_period_timer_tb_top;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst = 1'b1;
  logic        ext_clk = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        per_we = 1'b0;
  logic [15:0] per_wdata = '0;
  logic [15:0] ctl_q, cnt_q, per_q;
  logic        match_o, wake_o;

  int n_checks = 0;
  int n_fail   = 0;
  int match_seen = 0;
  int wake_seen  = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [15:0] cnt;
    logic [15:0] mt;
    logic [15:0] wk;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  exp_t  cur;
  string cur_tag;

  xclk_period_timer dut_i (
    .clk(clk), .rst(rst), .ext_clk(ext_clk),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .per_we(per_we), .per_wdata(per_wdata),
    .ctl_q(ctl_q), .cnt_q(cnt_q), .per_q(per_q),
    .match_o(match_o), .wake_o(wake_o)
  );

  initial forever begin
    #2;
    if (clk_run) clk = ~clk;
  end

  always @(negedge clk) if (!rst && match_o) match_seen++;
  always @(posedge wake_o) wake_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur     = sb_q.pop_front();
      cur_tag = tag_q.pop_front();
      chk({cur_tag, " count"}, 32'(cnt_q), 32'(cur.cnt));
      chk({cur_tag, " match_o total"}, 32'(match_seen), 32'(cur.mt));
      chk({cur_tag, " wake_o total"}, 32'(wake_seen), 32'(cur.wk));
    end
  end

  task automatic ctl_w(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic cnt_w(input logic [15:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic per_w(input logic [15:0] v);
    @(negedge clk); per_we = 1'b1; per_wdata = v;
    @(negedge clk); per_we = 1'b0;
  endtask

  task automatic ext_edge();
    @(negedge clk); ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ext_edge_free();
    #20 ext_clk = 1'b1;
    #20 ext_clk = 1'b0;
    #5;
  endtask

  // Driver: one external edge, then queue what the ports must show.
  task automatic edge_exp(input logic [15:0] c, input int m, input int w, input string tag);
    ext_edge();
    sb_q.push_back('{cnt: c, mt: 16'(m), wk: 16'(w)});
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", 32'(ctl_q), 32'h0);
    chk("R1 cnt", 32'(cnt_q), 32'h0);
    chk("R1 per", 32'(per_q), 32'h0);
    chk("R1 match_o", 32'(match_o), 32'h0);
    chk("R1 wake_o", 32'(wake_o), 32'h0);

    // R2 field layout: 0xFFFF reads back 0x8036
    ctl_w(16'hFFFF);
    chk("R2 ctl readback", 32'(ctl_q), 32'h8036);
    ctl_w(16'h0000);
    chk("R2 ctl cleared", 32'(ctl_q), 32'h0);

    // R3 R4 R5 sync mode 1:1, period 3
    per_w(16'd3);
    cnt_w(16'd0);
    ctl_w(16'h8006);
    edge_exp(16'd0, 0, 0, "R5 startup edge 1");
    edge_exp(16'd0, 0, 0, "R5 startup edge 2");
    edge_exp(16'd1, 0, 0, "R3 first count");
    edge_exp(16'd2, 0, 0, "R3 second count");
    edge_exp(16'd3, 1, 1, "R4 match at period");
    edge_exp(16'd0, 1, 1, "R4 wrap to zero");
    edge_exp(16'd1, 1, 1, "R4 after wrap");
    drain();

    // R8 writes ignored while enabled
    cnt_w(16'h0055);
    per_w(16'd9);
    @(negedge clk);
    chk("R8 count write ignored", 32'(cnt_q), 32'd1);
    chk("R8 period write ignored", 32'(per_q), 32'd3);

    // R7 disable keeps count; R8 writes accepted when disabled
    ctl_w(16'h0006);
    chk("R7 count kept on disable", 32'(cnt_q), 32'd1);
    cnt_w(16'd0);
    per_w(16'd100);
    chk("R8 count write accepted", 32'(cnt_q), 32'd0);
    chk("R8 period write accepted", 32'(per_q), 32'd100);

    // R6 R7 prescale 1:8 and prescaler reset on disable
    ctl_w(16'h8016);
    for (int i = 0; i < 7; i++) edge_exp(16'd0, 1, 1, "R6 div8 partial");
    drain();
    ctl_w(16'h0016);
    ctl_w(16'h8016);
    for (int i = 0; i < 9; i++) edge_exp(16'd0, 1, 1, "R7 prescaler restarted");
    edge_exp(16'd1, 1, 1, "R6 div8 eighth edge");
    for (int i = 0; i < 7; i++) edge_exp(16'd1, 1, 1, "R6 div8 hold");
    edge_exp(16'd2, 1, 1, "R6 div8 second tick");
    drain();

    // R6 prescale 1:64
    ctl_w(16'h0026);
    cnt_w(16'd0);
    ctl_w(16'h8026);
    for (int i = 0; i < 65; i++) ext_edge();
    drain();
    chk("R6 div64 before tick", 32'(cnt_q), 32'd0);
    edge_exp(16'd1, 1, 1, "R6 div64 tick");
    drain();

    // R6 prescale 1:256
    ctl_w(16'h0036);
    cnt_w(16'd0);
    ctl_w(16'h8036);
    for (int i = 0; i < 257; i++) ext_edge();
    drain();
    chk("R6 div256 before tick", 32'(cnt_q), 32'd0);
    edge_exp(16'd1, 1, 1, "R6 div256 tick");
    drain();

    // R11 external source not selected
    ctl_w(16'h0004);
    ctl_w(16'h8004);
    for (int i = 0; i < 5; i++) edge_exp(16'd1, 1, 1, "R11 no source no count");
    drain();

    // R9 R10 unsync mode, period 2
    ctl_w(16'h0002);
    cnt_w(16'd0);
    per_w(16'd2);
    ctl_w(16'h8002);
    edge_exp(16'd0, 1, 1, "R5 unsync startup 1");
    edge_exp(16'd0, 1, 1, "R5 unsync startup 2");
    edge_exp(16'd1, 1, 1, "R9 unsync count");
    edge_exp(16'd2, 2, 2, "R10 unsync match transferred");
    edge_exp(16'd0, 2, 2, "R4 unsync wrap");
    drain();

    // R9 R10 unsync keeps counting with bus clock stopped
    clk_run = 1'b0;
    ext_edge_free();
    chk("R9 stopped clock count 1", 32'(cnt_q), 32'd1);
    ext_edge_free();
    chk("R9 stopped clock count 2", 32'(cnt_q), 32'd2);
    chk("R10 wake while stopped", 32'(wake_seen), 32'd3);
    ext_edge_free();
    chk("R9 stopped clock wrap", 32'(cnt_q), 32'd0);
    clk_run = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 match after restart", 32'(match_seen), 32'd3);

    // R9 sync mode stalls with bus clock stopped
    ctl_w(16'h0002);
    ctl_w(16'h8006);
    edge_exp(16'd0, 3, 3, "R5 sync restart 1");
    edge_exp(16'd0, 3, 3, "R5 sync restart 2");
    edge_exp(16'd1, 3, 3, "R3 sync count");
    drain();
    clk_run = 1'b0;
    ext_edge_free();
    ext_edge_free();
    chk("R9 sync stalled", 32'(cnt_q), 32'd1);
    clk_run = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 sync stalled after restart", 32'(cnt_q), 32'd1);

    // R4 period zero: match every counted edge
    ctl_w(16'h0006);
    per_w(16'd0);
    cnt_w(16'd0);
    ctl_w(16'h8006);
    edge_exp(16'd0, 3, 3, "R5 period0 startup 1");
    edge_exp(16'd0, 3, 3, "R5 period0 startup 2");
    edge_exp(16'd0, 4, 4, "R4 period0 match 1");
    edge_exp(16'd0, 5, 5, "R4 period0 match 2");
    drain();

    done = 1'b1;
    finish_run();
  end
endmodule